// File: doc/BRIEF.md
# Window Watchdog with Reset Generator

This block supervises a host controller and drives an active-low reset line. When the supply-good input goes high, the reset line stays low for a fixed hold time. After that the host gets a long lead time to deliver its first trigger. From then on, every trigger has to land in an open window, and each open window follows a closed window. A trigger that comes too early, or one that never comes, produces a reset pulse of fixed width. The lead time then starts over.

Durations are counted in pulses of a slow `tick` input. The tick rate stands in for an oscillator whose frequency is set outside the block. There are two trigger inputs:
- an active-low input, which triggers on a falling edge;
- an optional active-high input, which triggers on a rising edge.

A trigger level must be held for a minimum number of clock cycles before it counts. A disable input and a low-power input each park the supervisor so that it never resets the host. A two-bit cause output reports why the last reset happened.

Top module: `win_watchdog`

## Requirements
- R1: While `rst_n` is low and while `pwr_good` is low, `rst_out_n` is low. After `pwr_good` goes high, `rst_out_n` stays low for exactly HOLD_TICKS sampled ticks and then goes high.
- R2: After the hold ends, the lead time begins. If no trigger event arrives within LEAD_TICKS ticks, `rst_out_n` goes low on the LEAD_TICKS-th tick and `cause` becomes 2'b11 (timeout).
- R3: A watchdog reset keeps `rst_out_n` low for exactly PULSE_TICKS ticks. Then `rst_out_n` goes high and a fresh lead time of LEAD_TICKS ticks begins.
- R4: A trigger event during the lead time starts a closed window of CLOSED_TICKS ticks, followed by an open window of OPEN_TICKS ticks. A trigger event inside the open window is accepted: `rst_out_n` stays high and a new closed window starts.
- R5: A trigger event inside the closed window drives `rst_out_n` low on the next clock and sets `cause` to 2'b10 (early).
- R6: If the open window passes with no trigger event, `rst_out_n` goes low on its last tick and `cause` becomes 2'b11.
- R7: A trigger event is either of two input patterns:
  - `trig_n` falls and stays low for MIN_PW_CLKS clock cycles;
  - `trig_p` rises and stays high for MIN_PW_CLKS clock cycles, when POS_TRIG_EN is set.
- R8: A trigger pulse shorter than MIN_PW_CLKS cycles is ignored.
- R9: While `wd_off` is high, the watchdog never produces a reset and trigger events have no effect. The timing restarts from a fresh lead time once `wd_off` returns low.
- R10: `low_power` high has the same effect as `wd_off` high.
- R11: `pwr_good` low drives `rst_out_n` low on the next clock from any state, including during a watchdog pulse, and sets `cause` to 2'b01 (undervoltage). 2'b01 is also the value of `cause` out of reset.
- R12: A trigger event that lands on the same clock as the final tick of a window is handled as follows:
  - on the final tick of the open window, it is accepted;
  - on the final tick of the closed window, it is early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse of the slow time base |
| pwr_good | input | 1 | Supply-good indication |
| trig_n | input | 1 | Active-low trigger (falling edge) |
| trig_p | input | 1 | Active-high trigger (rising edge) |
| wd_off | input | 1 | Disables the watchdog |
| low_power | input | 1 | Low-power mode; stops the watchdog |
| rst_out_n | output | 1 | Active-low reset to the host |
| cause | output | 2 | Reason for the last reset: 01 undervoltage, 10 early, 11 timeout |

## Verification
A qualified trigger event can complete on the same clock as the tick that ends a window. The bench forces this case at two points:
- It lines up the trigger pulse so that its qualification finishes exactly on the final tick of the open window. The block must accept the trigger and start a new closed window. A full closed-plus-open interval is then counted from the following tick, which shows that the tick on that clock was not counted.
- It repeats the alignment on the final tick of the closed window. The result must be an early reset.

// File: rtl/win_watchdog.sv
`timescale 1ns/1ps
module win_watchdog #(
  parameter int HOLD_TICKS   = 10,
  parameter int LEAD_TICKS   = 49,
  parameter int CLOSED_TICKS = 10,
  parameter int OPEN_TICKS   = 11,
  parameter int PULSE_TICKS  = 2,
  parameter int MIN_PW_CLKS  = 4,
  parameter bit POS_TRIG_EN  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pwr_good,
  input  logic       trig_n,
  input  logic       trig_p,
  input  logic       wd_off,
  input  logic       low_power,
  output logic       rst_out_n,
  output logic [1:0] cause
);
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXT = mx(mx(mx(HOLD_TICKS, LEAD_TICKS), mx(CLOSED_TICKS, OPEN_TICKS)), PULSE_TICKS);
  localparam int CW = (MAXT > 1) ? $clog2(MAXT) : 1;
  localparam int PW = $clog2(MIN_PW_CLKS + 1);
  localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] LEAD_LAST   = CW'(LEAD_TICKS - 1);
  localparam logic [CW-1:0] CLOSED_LAST = CW'(CLOSED_TICKS - 1);
  localparam logic [CW-1:0] OPEN_LAST   = CW'(OPEN_TICKS - 1);
  localparam logic [CW-1:0] PULSE_LAST  = CW'(PULSE_TICKS - 1);
  localparam logic [PW-1:0] PW_LAST     = PW'(MIN_PW_CLKS - 1);
  localparam logic [PW-1:0] PW_FULL     = PW'(MIN_PW_CLKS);
  localparam logic [1:0] C_UV = 2'b01, C_EARLY = 2'b10, C_TMO = 2'b11;

  typedef enum logic [2:0] {S_HOLD, S_LEAD, S_CLOSED, S_OPEN, S_PULSE} st_t;

  st_t st, nst;
  logic [CW-1:0] cnt, ncnt;
  logic [1:0] ncause;
  logic [1:0] sn;
  logic [PW-1:0] pwn;
  logic fire_n, fire_p, trig, idle;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sn  <= 2'b11;
      pwn <= '0;
    end else begin
      sn <= {sn[0], trig_n};
      if (sn[1]) pwn <= '0;
      else if (pwn != PW_FULL) pwn <= pwn + PW'(1);
    end

  assign fire_n = !sn[1] && (pwn == PW_LAST);

  generate
    if (POS_TRIG_EN) begin : g_pos
      logic [1:0] sp;
      logic [PW-1:0] pwp;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          sp  <= 2'b00;
          pwp <= '0;
        end else begin
          sp <= {sp[0], trig_p};
          if (!sp[1]) pwp <= '0;
          else if (pwp != PW_FULL) pwp <= pwp + PW'(1);
        end
      assign fire_p = sp[1] && (pwp == PW_LAST);
    end else begin : g_nopos
      assign fire_p = 1'b0;
    end
  endgenerate

  assign trig = fire_n | fire_p;
  assign idle = wd_off | low_power;

  always_comb begin
    nst = st;
    ncnt = cnt;
    ncause = cause;
    case (st)
      S_HOLD, S_PULSE: begin
        if (tick) begin
          if (cnt == ((st == S_HOLD) ? HOLD_LAST : PULSE_LAST)) begin
            nst = S_LEAD;
            ncnt = '0;
          end else ncnt = cnt + CW'(1);
        end
      end
      S_LEAD: begin
        if (idle) ncnt = '0;
        else if (trig) begin
          nst = S_CLOSED;
          ncnt = '0;
        end else if (tick) begin
          if (cnt == LEAD_LAST) begin
            nst = S_PULSE;
            ncnt = '0;
            ncause = C_TMO;
          end else ncnt = cnt + CW'(1);
        end
      end
      S_CLOSED: begin
        if (idle) begin
          nst = S_LEAD;
          ncnt = '0;
        end else if (trig) begin
          nst = S_PULSE;
          ncnt = '0;
          ncause = C_EARLY;
        end else if (tick) begin
          if (cnt == CLOSED_LAST) begin
            nst = S_OPEN;
            ncnt = '0;
          end else ncnt = cnt + CW'(1);
        end
      end
      S_OPEN: begin
        if (idle) begin
          nst = S_LEAD;
          ncnt = '0;
        end else if (trig) begin
          nst = S_CLOSED;
          ncnt = '0;
        end else if (tick) begin
          if (cnt == OPEN_LAST) begin
            nst = S_PULSE;
            ncnt = '0;
            ncause = C_TMO;
          end else ncnt = cnt + CW'(1);
        end
      end
      default: begin
        nst = S_HOLD;
        ncnt = '0;
      end
    endcase
    if (!pwr_good) begin
      nst = S_HOLD;
      ncnt = '0;
      ncause = C_UV;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_HOLD;
      cnt <= '0;
      cause <= C_UV;
    end else begin
      st <= nst;
      cnt <= ncnt;
      cause <= ncause;
    end

  assign rst_out_n = (st == S_LEAD) || (st == S_CLOSED) || (st == S_OPEN);

  p_uv_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!rst_out_n && cause == C_UV));

  p_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLOSED && trig && !idle && pwr_good) |=> (!rst_out_n && cause == C_EARLY));

  p_open_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPEN && trig && !idle && pwr_good) |=> (rst_out_n && st == S_CLOSED && cnt == '0));

  p_open_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPEN && tick && cnt == OPEN_LAST && !trig && !idle && pwr_good) |=> (!rst_out_n && cause == C_TMO));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pwr_good && rst_out_n) |=> rst_out_n);

  p_cause_on_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cause) |-> !rst_out_n);
endmodule

// File: tb/tb_win_watchdog.sv
`timescale 1ns/1ps
module tb_win_watchdog;
  localparam int HOLD = 10, LEAD = 49, CLOSED = 10, OPEN = 11, PULSE = 2, MINPW = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pwr_good = 1'b0;
  logic trig_n = 1'b1, trig_p = 1'b0, wd_off = 1'b0, low_power = 1'b0;
  logic rst_out_n;
  logic [1:0] cause;
  int checks = 0, errors = 0;

  win_watchdog #(.HOLD_TICKS(HOLD), .LEAD_TICKS(LEAD), .CLOSED_TICKS(CLOSED),
    .OPEN_TICKS(OPEN), .PULSE_TICKS(PULSE), .MIN_PW_CLKS(MINPW), .POS_TRIG_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_good(pwr_good), .trig_n(trig_n),
    .trig_p(trig_p), .wd_off(wd_off), .low_power(low_power),
    .rst_out_n(rst_out_n), .cause(cause));

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      repeat (7) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (tick !== 1'b1) @(posedge clk);
    end
    #1;
  endtask

  task automatic pulse_n(input int len);
    trig_n = 1'b0;
    repeat (len) @(negedge clk);
    trig_n = 1'b1;
  endtask

  task automatic pulse_p(input int len);
    trig_p = 1'b1;
    repeat (len) @(negedge clk);
    trig_p = 1'b0;
  endtask

  task automatic power_up();
    @(negedge clk);
    pwr_good = 1'b0;
    wd_off = 1'b0;
    low_power = 1'b0;
    repeat (2) @(negedge clk);
    pwr_good = 1'b1;
    wait_ticks(HOLD);
  endtask

  task automatic first_trig();
    @(negedge clk);
    pulse_n(5);
    @(negedge clk);
  endtask

  task automatic t_reset_hold();
    chk("R1", "rst_out_n under reset", rst_out_n, 0);
    chk("R11", "cause out of reset", cause, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "rst_out_n while pwr_good low", rst_out_n, 0);
    pwr_good = 1'b1;
    wait_ticks(HOLD - 1);
    chk("R1", "rst_out_n one tick before hold end", rst_out_n, 0);
    wait_ticks(1);
    chk("R1", "rst_out_n after hold", rst_out_n, 1);
  endtask

  task automatic t_lead_timeout();
    wait_ticks(LEAD - 1);
    chk("R2", "rst_out_n before lead expiry", rst_out_n, 1);
    wait_ticks(1);
    chk("R2", "rst_out_n at lead expiry", rst_out_n, 0);
    chk("R2", "cause at lead expiry", cause, 3);
    wait_ticks(PULSE - 1);
    chk("R3", "rst_out_n inside pulse", rst_out_n, 0);
    wait_ticks(1);
    chk("R3", "rst_out_n after pulse", rst_out_n, 1);
    wait_ticks(LEAD - 1);
    chk("R3", "rst_out_n lead restarted", rst_out_n, 1);
    wait_ticks(1);
    chk("R3", "rst_out_n second lead expiry", rst_out_n, 0);
  endtask

  task automatic t_window();
    power_up();
    first_trig();
    chk("R4", "rst_out_n after first trigger", rst_out_n, 1);
    for (int i = 0; i < 3; i++) begin
      wait_ticks(CLOSED + i);
      @(negedge clk);
      pulse_n(5);
      @(negedge clk);
      chk("R4", "rst_out_n after open-window trigger", rst_out_n, 1);
    end
    wait_ticks(CLOSED + OPEN - 1);
    chk("R6", "rst_out_n before open expiry", rst_out_n, 1);
    wait_ticks(1);
    chk("R6", "rst_out_n at open expiry", rst_out_n, 0);
    chk("R6", "cause at open expiry", cause, 3);
  endtask

  task automatic t_early();
    power_up();
    first_trig();
    wait_ticks(CLOSED - 1);
    @(negedge clk);
    pulse_n(5);
    @(negedge clk);
    chk("R5", "rst_out_n after early trigger", rst_out_n, 0);
    chk("R5", "cause after early trigger", cause, 2);
  endtask

  task automatic t_pos();
    power_up();
    @(negedge clk);
    pulse_p(5);
    @(negedge clk);
    wait_ticks(CLOSED);
    @(negedge clk);
    pulse_p(5);
    @(negedge clk);
    chk("R7", "rst_out_n after positive trigger in open", rst_out_n, 1);
    wait_ticks(2);
    @(negedge clk);
    pulse_p(5);
    @(negedge clk);
    chk("R7", "rst_out_n positive trigger in closed", rst_out_n, 0);
    chk("R7", "cause positive early", cause, 2);
  endtask

  task automatic t_short();
    power_up();
    first_trig();
    wait_ticks(2);
    @(negedge clk);
    pulse_n(MINPW - 1);
    repeat (2) @(negedge clk);
    chk("R8", "rst_out_n after short low pulse in closed", rst_out_n, 1);
    chk("R8", "cause after short low pulse", cause, 1);
    wait_ticks(1);
    @(negedge clk);
    pulse_p(MINPW - 1);
    repeat (2) @(negedge clk);
    chk("R8", "rst_out_n after short high pulse in closed", rst_out_n, 1);
    wait_ticks(CLOSED - 3);
    @(negedge clk);
    pulse_n(5);
    @(negedge clk);
    chk("R8", "rst_out_n valid trigger after glitches", rst_out_n, 1);
    wait_ticks(CLOSED + OPEN - 1);
    chk("R8", "rst_out_n window timed from valid trigger", rst_out_n, 1);
    wait_ticks(1);
    chk("R8", "rst_out_n expiry from valid trigger", rst_out_n, 0);
  endtask

  task automatic t_idle(input bit use_lp);
    string rq;
    rq = use_lp ? "R10" : "R9";
    power_up();
    first_trig();
    if (use_lp) low_power = 1'b1; else wd_off = 1'b1;
    wait_ticks(2);
    @(negedge clk);
    pulse_n(5);
    @(negedge clk);
    chk(rq, "rst_out_n trigger while parked", rst_out_n, 1);
    chk(rq, "cause while parked", cause, 1);
    wait_ticks(LEAD + OPEN + 5);
    chk(rq, "rst_out_n long parked", rst_out_n, 1);
    @(negedge clk);
    wd_off = 1'b0;
    low_power = 1'b0;
    wait_ticks(LEAD - 1);
    chk(rq, "rst_out_n fresh lead after release", rst_out_n, 1);
    wait_ticks(1);
    chk(rq, "rst_out_n lead expiry after release", rst_out_n, 0);
  endtask

  task automatic t_uv();
    power_up();
    first_trig();
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R11", "rst_out_n after supply loss", rst_out_n, 0);
    chk("R11", "cause after supply loss", cause, 1);
    power_up();
    wait_ticks(LEAD);
    chk("R11", "cause in pulse", cause, 3);
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R11", "cause after loss mid-pulse", cause, 1);
    pwr_good = 1'b1;
    wait_ticks(HOLD - 1);
    chk("R11", "rst_out_n hold after mid-pulse loss", rst_out_n, 0);
    wait_ticks(1);
    chk("R11", "rst_out_n release after hold", rst_out_n, 1);
  endtask

  task automatic t_coincide();
    power_up();
    first_trig();
    wait_ticks(CLOSED + OPEN - 1);
    repeat (3) @(negedge clk);
    pulse_n(5);
    @(negedge clk);
    chk("R12", "rst_out_n trigger on open final tick", rst_out_n, 1);
    wait_ticks(CLOSED + OPEN - 1);
    chk("R12", "rst_out_n window restarted at coincidence", rst_out_n, 1);
    wait_ticks(1);
    chk("R12", "rst_out_n expiry after coincidence", rst_out_n, 0);
    power_up();
    first_trig();
    wait_ticks(CLOSED - 1);
    repeat (3) @(negedge clk);
    pulse_n(5);
    @(negedge clk);
    chk("R12", "rst_out_n trigger on closed final tick", rst_out_n, 0);
    chk("R12", "cause trigger on closed final tick", cause, 2);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12;
    t_reset_hold();
    t_lead_timeout();
    t_window();
    t_early();
    t_pos();
    t_short();
    t_idle(1'b0);
    t_idle(1'b1);
    t_uv();
    t_coincide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule